// File: doc/BRIEF.md
# Page Access Permission Evaluator

This block decides whether a memory access may proceed once the page-table entry for its page has been found. Three separate sources of rights are combined: a protection table indexed by a 3-bit code and one key bit taken from the segment, the entry's no-execute and guarded bits, and a pair of authority mask registers indexed by the entry's protection key. The result is the access's read/write/execute rights, a grant or fault decision, the fault status flags, and requests to set the entry's referenced and changed bits.

A translation pipeline presents one request per cycle on `req_valid` with the access type, the privilege state and the entry fields. One cycle later the response appears. Writing the updated bits back to memory and raising the exception are left to the caller. The changed bit is handled lazily: a non-store access to a page whose changed bit is still clear gets its write right withheld, so the first store comes back through this path and raises the update request.

Top module: `page_rights_eval`

## Requirements
- R1: The key bit used for the table is `seg_key_user` when `req_user` is 1 and `seg_key_sup` when `req_user` is 0.
- R2: The protection code is {`pte_pp0`, `pte_pp`}. With key 0, codes 0, 1 and 2 give read/write/execute, codes 3 and 6 give read/execute, and codes 4, 5 and 7 give nothing.
- R3: With key 1, code 2 gives read/write/execute, codes 1 and 3 give read/execute, and codes 0, 4, 5, 6 and 7 give nothing.
- R4: A set `pte_noexec` or `pte_guard` removes only the execute right.
- R5: When the parameter HAS_AUTH_MASK is 1, the bit pair of key k sits at bit 2*(2^KEY_W-1-k) of the masks. In `auth_mask` the upper bit of the pair denies stores and the lower bit denies loads. In `fetch_mask` the lower bit denies fetches. When HAS_AUTH_MASK is 0, the masks have no effect.
- R6: The rights are the AND of the three sources. `req_acc` encodes 0 as fetch (needs execute), 1 as load (needs read), 2 as store (needs write) and 3 as load. `rsp_fault` is 1 exactly when the needed right is missing, and `rsp_grant` is its complement.
- R7: A faulting load or store sets `flt_prot` if the table lacks the needed right, sets `flt_mask` if the authority mask lacks it, and sets `flt_store` for a store. `flt_nxg` stays 0.
- R8: A faulting fetch sets `flt_nxg` if no-execute or guarded removed execute. Otherwise it sets `flt_prot` if the table lacks execute. It also sets `flt_mask` if the fetch mask lacks execute. `flt_store` stays 0.
- R9: `upd_ref` is 1 for a granted access whose `pte_ref` is 0.
- R10: `upd_chg` is 1 only for a granted store whose `pte_chg` is 0. For any other access with `pte_chg` 0, the write bit of `rsp_rights` is cleared.
- R11: Every output is registered. The response appears in the cycle after the request. When `req_valid` was 0, all outputs are 0.
- R12: After a synchronous active-low reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_acc | input | 2 | Access type: 0 fetch, 1 load, 2 store, 3 load |
| req_user | input | 1 | Unprivileged access |
| seg_key_user | input | 1 | Segment key for unprivileged accesses |
| seg_key_sup | input | 1 | Segment key for privileged accesses |
| pte_pp | input | 2 | Low two bits of the protection code |
| pte_pp0 | input | 1 | Top bit of the protection code |
| pte_noexec | input | 1 | Entry no-execute bit |
| pte_guard | input | 1 | Entry guarded bit |
| pte_ref | input | 1 | Entry referenced bit |
| pte_chg | input | 1 | Entry changed bit |
| pte_key | input | KEY_W | Entry protection key |
| auth_mask | input | 2*2^KEY_W | Load/store authority mask |
| fetch_mask | input | 2*2^KEY_W | Fetch authority mask |
| rsp_valid | output | 1 | Response present |
| rsp_rights | output | 3 | Rights: bit 2 read, bit 1 write, bit 0 execute |
| rsp_grant | output | 1 | Access allowed |
| rsp_fault | output | 1 | Access denied |
| flt_nxg | output | 1 | Fetch denied by no-execute/guarded |
| flt_prot | output | 1 | Denied by the protection table |
| flt_store | output | 1 | Faulting access was a store |
| flt_mask | output | 1 | Denied by an authority mask |
| upd_ref | output | 1 | Request to set the referenced bit |
| upd_chg | output | 1 | Request to set the changed bit |

## Verification
The only internal state is the response register. If it holds a wrong value, that value shows on every output in the very cycle after the request. Stale data would appear as an output that is non-zero while `rsp_valid` is low, or as a response that does not match the previous cycle's request. A wrong table entry or mask bit position shows up at once as a wrong grant/fault decision or as wrong flags. So the bench compares the full output vector one cycle after each request, with and without the lazy changed-bit rule in play.

// File: rtl/perm_eval_pkg.sv
// Shared types for the page permission evaluator.
// Assumes rights are carried as a 3-bit vector: read, write, execute.
package perm_eval_pkg;
    typedef logic [2:0] rights_t;
    localparam int RT_RD = 2;
    localparam int RT_WR = 1;
    localparam int RT_EX = 0;
    localparam rights_t RIGHTS_ALL  = 3'b111;
    localparam rights_t RIGHTS_RX   = 3'b101;
    localparam rights_t RIGHTS_NONE = 3'b000;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2,
        ACC_ALT   = 2'd3
    } acc_e;
endpackage

// File: rtl/perm_code_table.sv
// Rights granted by the 3-bit protection code under a one-bit key.
// Assumes the unlisted codes grant nothing.
module perm_code_table
    import perm_eval_pkg::*;
(
    input  logic       key,
    input  logic [2:0] code,
    output rights_t    rights
);
    // Look up the rights for the code under the selected key.
    always_comb begin
        rights = RIGHTS_NONE;
        if (!key) begin
            case (code)
                3'd0, 3'd1, 3'd2: rights = RIGHTS_ALL;
                3'd3, 3'd6:       rights = RIGHTS_RX;
                default:          rights = RIGHTS_NONE;
            endcase
        end else begin
            case (code)
                3'd2:       rights = RIGHTS_ALL;
                3'd1, 3'd3: rights = RIGHTS_RX;
                default:    rights = RIGHTS_NONE;
            endcase
        end
    end
endmodule

// File: rtl/perm_key_mask.sv
// Rights left by the per-key authority masks.
// Each key owns a bit pair at 2*(NKEYS-1-key).
// In the data mask, the upper bit denies stores and the lower bit denies loads.
// In the fetch mask, the lower bit denies fetches.
// With HAS_AUTH_MASK = 0, all rights pass.
module perm_key_mask
    import perm_eval_pkg::*;
#(
    parameter int KEY_W = 5,
    parameter bit HAS_AUTH_MASK = 1'b1,
    localparam int NKEYS = 1 << KEY_W,
    localparam int MASK_W = 2 * NKEYS
)(
    input  logic [KEY_W-1:0]  key,
    input  logic [MASK_W-1:0] data_mask,
    input  logic [MASK_W-1:0] inst_mask,
    output rights_t           rights
);
    generate
        if (HAS_AUTH_MASK) begin : g_mask
            logic [KEY_W:0] base;
            logic [1:0]     dpair;
            logic           ideny;
            // Pick this key's bit pair and clear the rights it denies.
            always_comb begin
                base  = {~key, 1'b0};
                dpair = data_mask[base +: 2];
                ideny = inst_mask[base];
                rights        = RIGHTS_ALL;
                rights[RT_WR] = ~dpair[1];
                rights[RT_RD] = ~dpair[0];
                rights[RT_EX] = ~ideny;
            end
        end else begin : g_nomask
            logic unused_mask;
            assign unused_mask = ^{key, data_mask, inst_mask};
            assign rights = RIGHTS_ALL;
        end
    endgenerate
endmodule

// File: rtl/page_rights_eval.sv
// Page access permission evaluator.
// Combines the protection table, the no-execute/guarded bits and the key masks.
// Decides grant or fault, builds the fault flags and the referenced/changed
// update requests, and registers everything for a one-cycle response.
// Assumes the page-table entry has already been matched.
module page_rights_eval
    import perm_eval_pkg::*;
#(
    parameter int KEY_W = 5,
    parameter bit HAS_AUTH_MASK = 1'b1,
    localparam int MASK_W = 2 * (1 << KEY_W)
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_acc,
    input  logic              req_user,
    input  logic              seg_key_user,
    input  logic              seg_key_sup,
    input  logic [1:0]        pte_pp,
    input  logic              pte_pp0,
    input  logic              pte_noexec,
    input  logic              pte_guard,
    input  logic              pte_ref,
    input  logic              pte_chg,
    input  logic [KEY_W-1:0]  pte_key,
    input  logic [MASK_W-1:0] auth_mask,
    input  logic [MASK_W-1:0] fetch_mask,
    output logic              rsp_valid,
    output logic [2:0]        rsp_rights,
    output logic              rsp_grant,
    output logic              rsp_fault,
    output logic              flt_nxg,
    output logic              flt_prot,
    output logic              flt_store,
    output logic              flt_mask,
    output logic              upd_ref,
    output logic              upd_chg
);
    logic    sel_key;
    rights_t code_r, nxg_r, mask_r, comb_r, need, out_r;
    logic    is_fetch, is_store, deny;
    logic    n_nxg, n_prot, n_store, n_mask;

    assign sel_key = req_user ? seg_key_user : seg_key_sup;

    perm_code_table u_table (
        .key    (sel_key),
        .code   ({pte_pp0, pte_pp}),
        .rights (code_r)
    );

    perm_key_mask #(.KEY_W(KEY_W), .HAS_AUTH_MASK(HAS_AUTH_MASK)) u_mask (
        .key       (pte_key),
        .data_mask (auth_mask),
        .inst_mask (fetch_mask),
        .rights    (mask_r)
    );

    // Combine the three sources and derive the right this access needs.
    always_comb begin
        nxg_r        = RIGHTS_ALL;
        nxg_r[RT_EX] = ~(pte_noexec | pte_guard);
        comb_r       = code_r & nxg_r & mask_r;
        is_fetch     = (req_acc == ACC_FETCH);
        is_store     = (req_acc == ACC_STORE);
        need         = RIGHTS_NONE;
        if (is_fetch)      need[RT_EX] = 1'b1;
        else if (is_store) need[RT_WR] = 1'b1;
        else               need[RT_RD] = 1'b1;
        deny         = |(need & ~comb_r);
        out_r        = comb_r;
        if (!pte_chg && !is_store) out_r[RT_WR] = 1'b0;
    end

    // Build the fault status flags for a denied fetch or data access.
    always_comb begin
        n_nxg   = 1'b0;
        n_prot  = 1'b0;
        n_store = 1'b0;
        n_mask  = 1'b0;
        if (deny && is_fetch) begin
            n_nxg  = ~nxg_r[RT_EX];
            n_prot = nxg_r[RT_EX] & ~code_r[RT_EX];
            n_mask = ~mask_r[RT_EX];
        end else if (deny) begin
            n_prot  = |(need & ~code_r);
            n_mask  = |(need & ~mask_r);
            n_store = is_store;
        end
    end

    // Register the response; outputs are zero when no request was present.
    always_ff @(posedge clk) begin
        if (!rst_n || !req_valid) begin
            rsp_valid  <= 1'b0;
            rsp_rights <= RIGHTS_NONE;
            rsp_grant  <= 1'b0;
            rsp_fault  <= 1'b0;
            flt_nxg    <= 1'b0;
            flt_prot   <= 1'b0;
            flt_store  <= 1'b0;
            flt_mask   <= 1'b0;
            upd_ref    <= 1'b0;
            upd_chg    <= 1'b0;
        end else begin
            rsp_valid  <= 1'b1;
            rsp_rights <= out_r;
            rsp_grant  <= ~deny;
            rsp_fault  <= deny;
            flt_nxg    <= n_nxg;
            flt_prot   <= n_prot;
            flt_store  <= n_store;
            flt_mask   <= n_mask;
            upd_ref    <= ~deny & ~pte_ref;
            upd_chg    <= ~deny & is_store & ~pte_chg;
        end
    end
endmodule

// File: rtl/page_rights_eval_chk.sv
// Temporal checks on the evaluator's ports, attached with bind.
module page_rights_eval_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic [1:0] req_acc,
    input logic       rsp_valid,
    input logic [2:0] rsp_rights,
    input logic       rsp_grant,
    input logic       rsp_fault,
    input logic       flt_nxg,
    input logic       flt_prot,
    input logic       flt_store,
    input logic       flt_mask,
    input logic       upd_ref,
    input logic       upd_chg
);
    a_r6_grant_xor_fault: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_grant ^ rsp_fault));
    a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && rsp_rights == 3'b000 && !rsp_grant && !rsp_fault
                        && !flt_nxg && !flt_prot && !flt_store && !flt_mask
                        && !upd_ref && !upd_chg));
    a_r10_chg_only_store: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_acc != 2'd2) |=> !upd_chg);
    a_r9_ref_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
        upd_ref |-> rsp_grant);
    a_r8_fetch_no_store_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_acc == 2'd0) |=> !flt_store);
    a_r7_store_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_acc == 2'd2) |=> (flt_store == rsp_fault));
    a_r7_data_no_nxg: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_acc != 2'd0) |=> !flt_nxg);
    a_r6_load_grant_read: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_acc == 2'd1) |=> (!rsp_grant || rsp_rights[2]));
    a_r8_flags_need_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_nxg || flt_prot || flt_mask) |-> rsp_fault);
endmodule

bind page_rights_eval page_rights_eval_chk i_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_acc(req_acc),
    .rsp_valid(rsp_valid), .rsp_rights(rsp_rights), .rsp_grant(rsp_grant),
    .rsp_fault(rsp_fault), .flt_nxg(flt_nxg), .flt_prot(flt_prot),
    .flt_store(flt_store), .flt_mask(flt_mask), .upd_ref(upd_ref), .upd_chg(upd_chg)
);

// File: tb/test_page_rights_eval.sv
module test_page_rights_eval;
    localparam int KW = 5;
    localparam int MW = 2 * (1 << KW);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [1:0] req_acc = '0;
    logic req_user = 1'b0, seg_key_user = 1'b0, seg_key_sup = 1'b0;
    logic [1:0] pte_pp = '0;
    logic pte_pp0 = 1'b0, pte_noexec = 1'b0, pte_guard = 1'b0;
    logic pte_ref = 1'b0, pte_chg = 1'b0;
    logic [KW-1:0] pte_key = '0;
    logic [MW-1:0] auth_mask = '0, fetch_mask = '0;
    logic rsp_valid, rsp_grant, rsp_fault, flt_nxg, flt_prot, flt_store, flt_mask;
    logic upd_ref, upd_chg;
    logic [2:0] rsp_rights;

    int checks = 0;
    int fails = 0;

    always #4 clk = ~clk;

    page_rights_eval #(.KEY_W(KW), .HAS_AUTH_MASK(1'b1)) i_page_rights_eval (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_acc(req_acc),
        .req_user(req_user), .seg_key_user(seg_key_user), .seg_key_sup(seg_key_sup),
        .pte_pp(pte_pp), .pte_pp0(pte_pp0), .pte_noexec(pte_noexec), .pte_guard(pte_guard),
        .pte_ref(pte_ref), .pte_chg(pte_chg), .pte_key(pte_key),
        .auth_mask(auth_mask), .fetch_mask(fetch_mask),
        .rsp_valid(rsp_valid), .rsp_rights(rsp_rights), .rsp_grant(rsp_grant),
        .rsp_fault(rsp_fault), .flt_nxg(flt_nxg), .flt_prot(flt_prot),
        .flt_store(flt_store), .flt_mask(flt_mask), .upd_ref(upd_ref), .upd_chg(upd_chg)
    );

    // Rights of the protection table, bit order {read, write, execute}.
    function automatic logic [2:0] tbl(input logic k, input logic [2:0] c);
        if (k == 1'b0) begin
            if (c <= 3'd2) return 3'b111;
            if (c == 3'd3 || c == 3'd6) return 3'b101;
            return 3'b000;
        end
        if (c == 3'd2) return 3'b111;
        if (c == 3'd1 || c == 3'd3) return 3'b101;
        return 3'b000;
    endfunction

    // Expected output vector: {valid, rights, grant, fault, nxg, prot, store, mask, ref, chg}.
    function automatic logic [11:0] expect_out();
        logic k, sw, ld, ix, need_r, need_w, need_x, bad, fetch, store;
        logic [2:0] t, m, nx, all_r, ret;
        int base;
        logic f_nxg, f_prot, f_st, f_mask;
        if (!req_valid) return 12'd0;
        k = req_user ? seg_key_user : seg_key_sup;
        t = tbl(k, {pte_pp0, pte_pp});
        base = 2 * ((1 << KW) - 1 - int'(pte_key));
        sw = auth_mask[base + 1];
        ld = auth_mask[base];
        ix = fetch_mask[base];
        m = {~ld, ~sw, ~ix};
        nx = {1'b1, 1'b1, ~(pte_noexec | pte_guard)};
        all_r = t & m & nx;
        fetch = (req_acc == 2'd0);
        store = (req_acc == 2'd2);
        need_x = fetch; need_w = store; need_r = !fetch && !store;
        bad = (need_x && !all_r[0]) || (need_w && !all_r[1]) || (need_r && !all_r[2]);
        ret = all_r;
        if (!pte_chg && !store) ret[1] = 1'b0;
        f_nxg = 0; f_prot = 0; f_st = 0; f_mask = 0;
        if (bad && fetch) begin
            f_nxg  = pte_noexec | pte_guard;
            f_prot = !f_nxg && !t[0];
            f_mask = ix;
        end else if (bad) begin
            f_st   = store;
            f_prot = store ? !t[1] : !t[2];
            f_mask = store ? sw : ld;
        end
        return {1'b1, ret, !bad, bad, f_nxg, f_prot, f_st, f_mask,
                !bad && !pte_ref, !bad && store && !pte_chg};
    endfunction

    function automatic logic [11:0] got_out();
        return {rsp_valid, rsp_rights, rsp_grant, rsp_fault, flt_nxg, flt_prot,
                flt_store, flt_mask, upd_ref, upd_chg};
    endfunction

    // Drive the current inputs, wait one edge, compare at the next falling edge.
    task automatic run_one(input string tag);
        logic [11:0] e;
        e = expect_out();
        @(posedge clk);
        @(negedge clk);
        checks++;
        if (got_out() !== e) begin
            fails++;
            $display("FAIL %s: got %03h expected %03h", tag, got_out(), e);
        end
    endtask

    task automatic set_req(input logic [1:0] acc, input logic usr, input logic ku,
                           input logic ks, input logic [2:0] code);
        req_valid = 1'b1; req_acc = acc; req_user = usr;
        seg_key_user = ku; seg_key_sup = ks;
        pte_pp0 = code[2]; pte_pp = code[1:0];
        pte_noexec = 0; pte_guard = 0; pte_ref = 1; pte_chg = 1;
        pte_key = '0; auth_mask = '0; fetch_mask = '0;
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] seed;
        seed = $urandom(32'h5eed_0119);
        repeat (3) @(negedge clk);
        // R12 reset state
        checks++;
        if (got_out() !== 12'd0) begin
            fails++;
            $display("FAIL R12: got %03h expected 000", got_out());
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R1 key selection follows privilege
        set_req(2'd1, 1'b1, 1'b1, 1'b0, 3'd0); run_one("R1");
        @(negedge clk); set_req(2'd1, 1'b0, 1'b1, 1'b0, 3'd0); run_one("R1");
        // R2 key 0 code 3 denies store, code 6 allows load, code 5 none
        @(negedge clk); set_req(2'd2, 1'b0, 1'b0, 1'b0, 3'd3); run_one("R2");
        @(negedge clk); set_req(2'd1, 1'b0, 1'b0, 1'b0, 3'd6); run_one("R2");
        @(negedge clk); set_req(2'd0, 1'b0, 1'b0, 1'b0, 3'd5); run_one("R2");
        // R3 key 1 code 2 store granted, code 6 load denied
        @(negedge clk); set_req(2'd2, 1'b0, 1'b0, 1'b1, 3'd2); run_one("R3");
        @(negedge clk); set_req(2'd1, 1'b0, 1'b0, 1'b1, 3'd6); run_one("R3");
        // R4 no-execute keeps read and write
        @(negedge clk); set_req(2'd2, 1'b0, 1'b0, 1'b0, 3'd0); pte_noexec = 1; run_one("R4");
        @(negedge clk); set_req(2'd0, 1'b0, 1'b0, 1'b0, 3'd0); pte_guard = 1; run_one("R4");
        // R5 mask pair for key 3 at bit 56: upper denies store
        @(negedge clk); set_req(2'd2, 1'b0, 1'b0, 1'b0, 3'd0); pte_key = 5'd3;
        auth_mask[57] = 1'b1; run_one("R5");
        @(negedge clk); set_req(2'd1, 1'b0, 1'b0, 1'b0, 3'd0); pte_key = 5'd3;
        auth_mask[57] = 1'b1; run_one("R5");
        // R5 key 31 pair at bit 0 denies load
        @(negedge clk); set_req(2'd3, 1'b0, 1'b0, 1'b0, 3'd0); pte_key = 5'd31;
        auth_mask[0] = 1'b1; run_one("R5");
        // R7 store denied by table and mask together
        @(negedge clk); set_req(2'd2, 1'b0, 1'b0, 1'b0, 3'd3); auth_mask[63] = 1'b1; run_one("R7");
        // R8 fetch: no-execute preferred to table fault, mask flag added
        @(negedge clk); set_req(2'd0, 1'b0, 1'b0, 1'b1, 3'd0); pte_noexec = 1;
        fetch_mask[62] = 1'b1; run_one("R8");
        @(negedge clk); set_req(2'd0, 1'b0, 1'b0, 1'b1, 3'd0); run_one("R8");
        @(negedge clk); set_req(2'd0, 1'b0, 1'b0, 1'b0, 3'd1); fetch_mask[62] = 1'b1; run_one("R8");
        // R9 referenced update on grant only
        @(negedge clk); set_req(2'd1, 1'b0, 1'b0, 1'b0, 3'd0); pte_ref = 0; run_one("R9");
        @(negedge clk); set_req(2'd1, 1'b0, 1'b0, 1'b1, 3'd0); pte_ref = 0; run_one("R9");
        // R10 lazy changed bit
        @(negedge clk); set_req(2'd1, 1'b0, 1'b0, 1'b0, 3'd0); pte_chg = 0; run_one("R10");
        @(negedge clk); set_req(2'd2, 1'b0, 1'b0, 1'b0, 3'd0); pte_chg = 0; run_one("R10");
        // R11 idle cycle gives a quiet response
        @(negedge clk); req_valid = 1'b0; run_one("R11");

        // R6 random mix
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            req_valid = ($urandom % 8) != 0;
            req_acc = 2'($urandom);
            req_user = 1'($urandom); seg_key_user = 1'($urandom); seg_key_sup = 1'($urandom);
            pte_pp = 2'($urandom); pte_pp0 = 1'($urandom);
            pte_noexec = ($urandom % 4) == 0; pte_guard = ($urandom % 5) == 0;
            pte_ref = 1'($urandom); pte_chg = 1'($urandom);
            pte_key = KW'($urandom);
            for (int j = 0; j < MW; j++) begin
                auth_mask[j] = ($urandom % 4) == 0;
                fetch_mask[j] = ($urandom % 4) == 0;
            end
            run_one("R6");
        end

        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule